// File: doc/BRIEF.md
# LCD Raster Sync and Clock Generator

This block produces the raster timing for a flat panel. It runs from a clock at twice the pixel rate. Every pixel takes two clock cycles. From that clock it drives five pins: a pixel clock, a line pulse, a frame pulse, an AC/output-enable pin and a data-valid strobe. Its inputs come straight from configuration registers:

- the horizontal sync width, the back porch and the front porch;
- the pixels per line and the lines per panel;
- the panel type, active or passive;
- the polarity of each pin;
- the pixel clock edge on which the syncs change.

A horizontal state machine walks each line through its phases. The state S_LOAD is entered on reset. From it the machine goes to S_HSYNC, then S_HBP, then S_HACT, then S_HFP. From S_HFP it returns to S_HSYNC for the next line. The last pixel of the front porch on the last line of a frame is the frame wrap: it also reloads the configuration snapshot and clears the line counter. Every other state leaves on its last pixel. A state whose length field holds N lasts N+1 pixels.

An active panel gets a free-running pixel clock and a frame pulse on one extra blanking line after the panel lines. A passive panel gets a pixel clock that pulses only while data is valid, and a frame pulse that covers the whole first line of each frame. All pins are registered and change together, one clock after the state that produces them. The exception is the line and frame pulses, which may be held one more clock to move them to the opposite pixel clock edge.

Top module: `lcd_raster_timing`

## Requirements
- R1: The sync width is 10 bits, made of `cfg_hsw_hi` (bits 9:6) above `cfg_hsw_lo` (bits 5:0). Each line runs sync, back porch, active pixels, front porch, in that order. A field value N lasts N+1 pixels of 2 clocks each, so the line pulse is 2*(hsw+1) clocks wide and a line lasts 2*(hsw+hbp+ppl+hfp+4) clocks.
- R2: The line count is 11 bits, made of `cfg_lpp_b10` as bit 10 above `cfg_lpp_lo`. A frame holds lpp+2 lines in active mode (lpp+1 panel lines plus one frame-pulse line) and lpp+1 lines in passive mode.
- R3: In active mode (`cfg_active`=1) the pixel clock toggles every clock cycle without a break, which gives one rising edge per pixel in every line, blanking included.
- R4: In passive mode the pixel clock pulses only while data is valid. Outside that time it rests at the level of `cfg_pclk_inv`: 0 is return-to-zero and 1 is return-to-one.
- R5: Data valid changes on the pixel clock edge where the clock leaves its `cfg_pclk_inv` level: the rising edge when the bit is 0, the falling edge when it is 1.
- R6: With `cfg_sync_edge_en`=0 the line and frame pulses change one clock after the data edge, on the opposite pixel clock edge. With it set to 1 in active mode, `cfg_sync_on_fall` picks the rising edge (0) or the falling edge (1). Passive mode always behaves as if the enable were 0.
- R7: `cfg_hs_inv` and `cfg_vs_inv` set the line and frame pulse polarity: 0 is active high and 1 is active low.
- R8: Data valid is high for 2*(ppl+1) clocks per line, starting 2*(hsw+hbp+2) clocks after the start of the line's sync phase. It is high on lpp+1 lines per frame. In active mode it is never high during the frame pulse. In passive mode it is high throughout line 0, inside the frame pulse.
- R9: In active mode the AC pin equals data valid XOR `cfg_oe_inv`. In passive mode it equals data valid, and `cfg_oe_inv` has no effect.
- R10: Configuration is captured only at reset and at frame wrap. A change made mid-frame takes effect on the first line of the next frame.
- R11: While `rst` is high, the outputs are: pixel clock = `cfg_pclk_inv`, line pulse = `cfg_hs_inv`, frame pulse = `cfg_vs_inv`, data valid = 0, and AC pin = `cfg_oe_inv` in active mode or 0 in passive mode. All counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hsw_lo | input | 6 | Sync width bits 5:0 |
| cfg_hsw_hi | input | 4 | Sync width bits 9:6 |
| cfg_hbp | input | 10 | Back porch, value N = N+1 pixels |
| cfg_hfp | input | 10 | Front porch, value N = N+1 pixels |
| cfg_ppl | input | 11 | Pixels per line minus one |
| cfg_lpp_lo | input | 10 | Lines per panel minus one, bits 9:0 |
| cfg_lpp_b10 | input | 1 | Lines per panel minus one, bit 10 |
| cfg_active | input | 1 | 1 = active panel, 0 = passive panel |
| cfg_pclk_inv | input | 1 | Pixel clock inversion / rest level |
| cfg_hs_inv | input | 1 | Line pulse active low when 1 |
| cfg_vs_inv | input | 1 | Frame pulse active low when 1 |
| cfg_oe_inv | input | 1 | AC pin active low in active mode when 1 |
| cfg_sync_edge_en | input | 1 | Enable explicit sync edge selection |
| cfg_sync_on_fall | input | 1 | Selected sync edge: 0 rising, 1 falling |
| pix_clk_o | output | 1 | Pixel clock pin |
| line_pulse_o | output | 1 | Horizontal sync pin |
| frame_pulse_o | output | 1 | Vertical sync pin |
| ac_o | output | 1 | AC-bias / output-enable pin |
| data_valid_o | output | 1 | Data-valid strobe, active high |

## Verification
The main function is driven with a table of timing sets. The sets cover both panel types, both pixel clock inversions, every pin polarity, all three sync edge choices, all-zero minimum fields, a sync width that needs the upper bit field, and a line count that needs bit 10. Measuring the line period, pulse widths, sync-to-data offset and frame period separates a wrong field assembly, a missing +1 and a wrong frame length. The pixel clock level sampled at the sync and data edges shows whether the sync delay or the data edge is wrong. Counting data-valid clocks inside the frame pulse, and checking the pixel clock rest level, separates passive behaviour from active behaviour. Directed tests cover the reset levels, `cfg_oe_inv` having no effect in passive mode, and a mid-frame change of the sync width.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    parameter int HSW_LO_W = 6;
    parameter int HSW_HI_W = 4;
    parameter int PORCH_W  = 10;
    parameter int PPL_W    = 11;
    parameter int LPP_LO_W = 10;

    localparam int HSW_W  = HSW_LO_W + HSW_HI_W;
    localparam int LPP_W  = LPP_LO_W + 1;
    localparam int LINE_W = LPP_W + 1;
    localparam int HMAX_W = (HSW_W > PORCH_W) ? HSW_W : PORCH_W;
    localparam int CNT_W  = (PPL_W > HMAX_W) ? PPL_W : HMAX_W;

    typedef enum logic [2:0] {
        S_LOAD,
        S_HSYNC,
        S_HBP,
        S_HACT,
        S_HFP
    } hstate_t;

    typedef struct packed {
        logic [HSW_W-1:0]   hsw;
        logic [PORCH_W-1:0] hbp;
        logic [PORCH_W-1:0] hfp;
        logic [PPL_W-1:0]   ppl;
        logic [LPP_W-1:0]   lpp;
        logic               active;
        logic               pclk_inv;
        logic               hs_inv;
        logic               vs_inv;
        logic               oe_inv;
        logic               edge_en;
        logic               edge_fall;
    } tcfg_t;

endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
    import lcd_sync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  tcfg_t live,
    output tcfg_t held
);

    // Snapshot taken during reset and at every frame boundary only.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            held <= live;
        end
    end

endmodule

// File: rtl/lcd_raster_fsm.sv
module lcd_raster_fsm
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tcfg_t             sh,
    output hstate_t           state,
    output logic              ph,
    output logic [LINE_W-1:0] line,
    output logic              load
);

    hstate_t            nxt;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lim;
    logic [LINE_W-1:0]  last_line;
    logic               last_px;
    logic               frame_wrap;

    // Length of the current horizontal phase, in pixels minus one.
    always_comb begin
        lim = '0;
        unique case (state)
            S_HSYNC: lim = CNT_W'(sh.hsw);
            S_HBP:   lim = CNT_W'(sh.hbp);
            S_HACT:  lim = CNT_W'(sh.ppl);
            S_HFP:   lim = CNT_W'(sh.hfp);
            default: lim = '0;
        endcase
    end

    always_comb begin
        last_line  = sh.active ? (LINE_W'(sh.lpp) + LINE_W'(1)) : LINE_W'(sh.lpp);
        last_px    = ph && (cnt == lim);
        frame_wrap = (state == S_HFP) && last_px && (line == last_line);
        load       = (state == S_LOAD) || frame_wrap;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            S_LOAD:  nxt = S_HSYNC;
            S_HSYNC: if (last_px) nxt = S_HBP;
            S_HBP:   if (last_px) nxt = S_HACT;
            S_HACT:  if (last_px) nxt = S_HFP;
            S_HFP:   if (last_px) nxt = S_HSYNC;
            default: nxt = S_LOAD;
        endcase
    end

    // State register together with phase, pixel and line counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_LOAD;
            ph    <= 1'b0;
            cnt   <= '0;
            line  <= '0;
        end else begin
            state <= nxt;
            if (state == S_LOAD) begin
                ph   <= 1'b0;
                cnt  <= '0;
                line <= '0;
            end else begin
                ph <= ~ph;
                if (ph) begin
                    cnt <= last_px ? '0 : cnt + CNT_W'(1);
                end
                if (frame_wrap) begin
                    line <= '0;
                end else if ((state == S_HFP) && last_px) begin
                    line <= line + LINE_W'(1);
                end
            end
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (state != S_LOAD) |-> (cnt <= lim));

    p_line_bound_r2: assert property (@(posedge clk) disable iff (rst)
        line <= last_line);

    p_ph_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (state != S_LOAD) |=> (ph != $past(ph)));

    p_wrap_to_line0_r10: assert property (@(posedge clk) disable iff (rst)
        (load && (state != S_LOAD)) |=> ((state == S_HSYNC) && (line == '0)));

endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tcfg_t             live,
    input  tcfg_t             sh,
    input  hstate_t           state,
    input  logic              ph,
    input  logic [LINE_W-1:0] line,
    output logic              pix_clk_q,
    output logic              hs_q,
    output logic              vs_q,
    output logic              de_q,
    output logic              ac_q
);

    logic in_frame;
    logic hs_lvl, vs_lvl, de_lvl, pc_lvl;
    logic hs_dly, vs_dly;
    logic sync_late;
    logic hs_sel, vs_sel;

    always_comb begin
        in_frame = (state != S_LOAD);
        hs_lvl   = (state == S_HSYNC);
        if (sh.active) begin
            vs_lvl = in_frame && (line == (LINE_W'(sh.lpp) + LINE_W'(1)));
            de_lvl = (state == S_HACT) && (line <= LINE_W'(sh.lpp));
            pc_lvl = in_frame ? (~ph ^ sh.pclk_inv) : sh.pclk_inv;
        end else begin
            vs_lvl = in_frame && (line == '0);
            de_lvl = (state == S_HACT);
            pc_lvl = de_lvl ? (~ph ^ sh.pclk_inv) : sh.pclk_inv;
        end
        // Data moves on the edge leaving the rest level; a late sync lands
        // on the other edge. Passive panels always take the late edge.
        sync_late = (sh.active && sh.edge_en) ? (sh.edge_fall ^ sh.pclk_inv) : 1'b1;
        hs_sel    = sync_late ? hs_dly : hs_lvl;
        vs_sel    = sync_late ? vs_dly : vs_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_dly    <= 1'b0;
            vs_dly    <= 1'b0;
            pix_clk_q <= live.pclk_inv;
            hs_q      <= live.hs_inv;
            vs_q      <= live.vs_inv;
            de_q      <= 1'b0;
            ac_q      <= live.active & live.oe_inv;
        end else begin
            hs_dly    <= hs_lvl;
            vs_dly    <= vs_lvl;
            pix_clk_q <= pc_lvl;
            hs_q      <= hs_sel ^ sh.hs_inv;
            vs_q      <= vs_sel ^ sh.vs_inv;
            de_q      <= de_lvl;
            ac_q      <= sh.active ? (de_lvl ^ sh.oe_inv) : de_lvl;
        end
    end

    p_passive_rest_r4: assert property (@(posedge clk) disable iff (rst)
        (!sh.active && !de_lvl) |=> (pix_clk_q == $past(sh.pclk_inv)));

    p_no_de_in_frame_line_r8: assert property (@(posedge clk) disable iff (rst)
        (sh.active && vs_lvl) |-> !de_lvl);

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (!de_q && (hs_q == $past(live.hs_inv)) && (vs_q == $past(live.vs_inv))));

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
    import lcd_sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [HSW_LO_W-1:0] cfg_hsw_lo,
    input  logic [HSW_HI_W-1:0] cfg_hsw_hi,
    input  logic [PORCH_W-1:0]  cfg_hbp,
    input  logic [PORCH_W-1:0]  cfg_hfp,
    input  logic [PPL_W-1:0]    cfg_ppl,
    input  logic [LPP_LO_W-1:0] cfg_lpp_lo,
    input  logic                cfg_lpp_b10,
    input  logic                cfg_active,
    input  logic                cfg_pclk_inv,
    input  logic                cfg_hs_inv,
    input  logic                cfg_vs_inv,
    input  logic                cfg_oe_inv,
    input  logic                cfg_sync_edge_en,
    input  logic                cfg_sync_on_fall,
    output logic                pix_clk_o,
    output logic                line_pulse_o,
    output logic                frame_pulse_o,
    output logic                ac_o,
    output logic                data_valid_o
);

    tcfg_t             live_cfg;
    tcfg_t             held_cfg;
    hstate_t           hstate;
    logic              phase;
    logic [LINE_W-1:0] line_idx;
    logic              snap;

    // Extension fields join their low parts here.
    always_comb begin
        live_cfg.hsw       = {cfg_hsw_hi, cfg_hsw_lo};
        live_cfg.hbp       = cfg_hbp;
        live_cfg.hfp       = cfg_hfp;
        live_cfg.ppl       = cfg_ppl;
        live_cfg.lpp       = {cfg_lpp_b10, cfg_lpp_lo};
        live_cfg.active    = cfg_active;
        live_cfg.pclk_inv  = cfg_pclk_inv;
        live_cfg.hs_inv    = cfg_hs_inv;
        live_cfg.vs_inv    = cfg_vs_inv;
        live_cfg.oe_inv    = cfg_oe_inv;
        live_cfg.edge_en   = cfg_sync_edge_en;
        live_cfg.edge_fall = cfg_sync_on_fall;
    end

    lcd_cfg_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (snap),
        .live (live_cfg),
        .held (held_cfg)
    );

    lcd_raster_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sh    (held_cfg),
        .state (hstate),
        .ph    (phase),
        .line  (line_idx),
        .load  (snap)
    );

    lcd_pin_drive u_pins (
        .clk       (clk),
        .rst       (rst),
        .live      (live_cfg),
        .sh        (held_cfg),
        .state     (hstate),
        .ph        (phase),
        .line      (line_idx),
        .pix_clk_q (pix_clk_o),
        .hs_q      (line_pulse_o),
        .vs_q      (frame_pulse_o),
        .de_q      (data_valid_o),
        .ac_q      (ac_o)
    );

endmodule

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic [5:0]  cfg_hsw_lo = '0;
    logic [3:0]  cfg_hsw_hi = '0;
    logic [9:0]  cfg_hbp = '0;
    logic [9:0]  cfg_hfp = '0;
    logic [10:0] cfg_ppl = '0;
    logic [9:0]  cfg_lpp_lo = '0;
    logic        cfg_lpp_b10 = 1'b0;
    logic        cfg_active = 1'b1;
    logic        cfg_pclk_inv = 1'b0;
    logic        cfg_hs_inv = 1'b0;
    logic        cfg_vs_inv = 1'b0;
    logic        cfg_oe_inv = 1'b0;
    logic        cfg_sync_edge_en = 1'b0;
    logic        cfg_sync_on_fall = 1'b0;
    logic        pix_clk_o, line_pulse_o, frame_pulse_o, ac_o, data_valid_o;

    lcd_raster_timing dut_i (.*);

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        int hsw; int hbp; int hfp; int ppl; int lpp;
        bit act; bit pinv; bit hinv; bit vinv; bit oeinv; bit en; bit fall; bit dly;
    } vec_t;

    // hsw hbp hfp ppl lpp | act pinv hinv vinv oe en fall | expected sync delay
    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2,   3, 1, 7, 2,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{130, 0, 0, 3, 1,    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1,   1, 2, 5, 3,    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{0,   0, 0, 0, 0,    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{3,   2, 2, 4, 2,    1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1,   0, 1, 6, 1,    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{0,   0, 0, 0, 1030, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    // Pin monitor, sampled on the falling clock edge.
    int cyc = 0;
    int hs_t, hs_per, hs_w, hs_falls;
    int de_t, de_w, hs2de, de_cnt, de_frame;
    int vs_t, vs_per, vs_w, dv_cnt, de_in_vs;
    int pcr_cnt, pcr_line, ac_bad, rest_bad;
    bit pc_at_hs, pc_at_de, pc_before_de;
    bit hs_p, vs_p, de_p, pn_p, pc_p;

    always @(negedge clk) begin
        bit hs, vs, de, pc, pn, exp_ac;
        cyc++;
        hs = line_pulse_o ^ cfg_hs_inv;
        vs = frame_pulse_o ^ cfg_vs_inv;
        de = data_valid_o;
        pc = pix_clk_o;
        pn = pc ^ cfg_pclk_inv;
        if (rst) begin
            hs_t = cyc; hs_per = 0; hs_w = 0; hs_falls = 0;
            de_t = cyc; de_w = 0; hs2de = 0; de_cnt = 0; de_frame = 0;
            vs_t = cyc; vs_per = 0; vs_w = 0; dv_cnt = 0; de_in_vs = 0;
            pcr_cnt = 0; pcr_line = 0; ac_bad = 0; rest_bad = 0;
        end else begin
            if (hs && !hs_p) begin
                hs_per = cyc - hs_t; hs_t = cyc; pc_at_hs = pc;
                pcr_line = pcr_cnt; pcr_cnt = 0;
            end
            if (!hs && hs_p) begin hs_w = cyc - hs_t; hs_falls++; end
            if (pn && !pn_p) pcr_cnt++;
            if (de && !de_p) begin
                hs2de = cyc - hs_t; de_t = cyc; pc_at_de = pc; pc_before_de = pc_p; de_cnt++;
            end
            if (!de && de_p) de_w = cyc - de_t;
            if (de && vs) dv_cnt++;
            if (vs && !vs_p) begin
                vs_per = cyc - vs_t; vs_t = cyc; de_frame = de_cnt; de_cnt = 0;
                de_in_vs = dv_cnt; dv_cnt = 0;
            end
            if (!vs && vs_p) vs_w = cyc - vs_t;
            exp_ac = cfg_active ? (de ^ cfg_oe_inv) : de;
            if (ac_o != exp_ac) ac_bad++;
            if (!cfg_active && !de && (pc != cfg_pclk_inv)) rest_bad++;
        end
        hs_p = hs; vs_p = vs; de_p = de; pn_p = pn; pc_p = pc;
    end

    task automatic apply(vec_t v);
        cfg_hsw_lo = v.hsw[5:0];   cfg_hsw_hi = v.hsw[9:6];
        cfg_hbp = v.hbp[9:0];      cfg_hfp = v.hfp[9:0];
        cfg_ppl = v.ppl[10:0];
        cfg_lpp_lo = v.lpp[9:0];   cfg_lpp_b10 = v.lpp[10];
        cfg_active = v.act;        cfg_pclk_inv = v.pinv;
        cfg_hs_inv = v.hinv;       cfg_vs_inv = v.vinv;
        cfg_oe_inv = v.oeinv;
        cfg_sync_edge_en = v.en;   cfg_sync_on_fall = v.fall;
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_falls(int n);
        int target = hs_falls + n;
        while (hs_falls < target) @(negedge clk);
    endtask

    task automatic run_vec(vec_t v);
        int L, lines, fr, dly;
        L     = 2 * (v.hsw + v.hbp + v.ppl + v.hfp + 4);
        lines = v.act ? v.lpp + 2 : v.lpp + 1;
        fr    = L * lines;
        dly   = v.dly ? 1 : 0;
        @(negedge clk);
        apply(v);
        restart();
        repeat (3 * fr + 20) @(negedge clk);
        chk_eq("R1", "line pulse width", hs_w, 2 * (v.hsw + 1));
        chk_eq("R1", "line period", hs_per, L);
        chk_eq("R2", "frame period", vs_per, fr);
        chk_eq("R7", "frame pulse width", vs_w, L);
        chk_eq("R8", "data valid width", de_w, 2 * (v.ppl + 1));
        chk_eq("R8", "data lines per frame", de_frame, v.lpp + 1);
        chk_eq("R8", "data valid inside frame pulse", de_in_vs, v.act ? 0 : 2 * (v.ppl + 1));
        chk_eq("R6", "sync to data offset", hs2de, 2 * (v.hsw + v.hbp + 2) - dly);
        chk_eq("R5", "pclk at data start", int'(pc_at_de), int'(!v.pinv));
        chk_eq("R5", "pclk before data start", int'(pc_before_de), int'(v.pinv));
        chk_eq("R9", "ac pin mismatches", ac_bad, 0);
        if (v.act) begin
            chk_eq("R3", "pclk rises per line", pcr_line, L / 2);
            chk_eq("R6", "pclk at line pulse start", int'(pc_at_hs), int'(v.dly ? v.pinv : !v.pinv));
        end else begin
            chk_eq("R4", "pclk rises per line", pcr_line, v.ppl + 1);
            chk_eq("R4", "pclk off rest level", rest_bad, 0);
        end
    endtask

    initial begin
        vec_t mv;
        // R11: reset levels, active mode.
        cfg_active = 1'b1; cfg_pclk_inv = 1'b1; cfg_hs_inv = 1'b1;
        cfg_vs_inv = 1'b0; cfg_oe_inv = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R11", "reset pclk", int'(pix_clk_o), 1);
        chk_eq("R11", "reset line pulse", int'(line_pulse_o), 1);
        chk_eq("R11", "reset frame pulse", int'(frame_pulse_o), 0);
        chk_eq("R11", "reset data valid", int'(data_valid_o), 0);
        chk_eq("R11", "reset ac active mode", int'(ac_o), 1);
        // R9: oe inversion has no effect in passive mode.
        cfg_active = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R9", "reset ac passive mode", int'(ac_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10: mid-frame width change waits for the next frame.
        mv = '{2, 1, 1, 3, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        @(negedge clk);
        apply(mv);
        restart();
        wait_falls(1);
        cfg_hsw_lo = 6'd5;
        wait_falls(1);
        chk_eq("R10", "width after mid-frame write", hs_w, 6);
        wait_falls(4);
        chk_eq("R10", "width in next frame", hs_w, 12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule